// File: doc/BRIEF.md
# Edge Capture and Interrupt Flag Unit

This block watches four capture inputs and, when an enabled edge appears on one of them, copies the current value of an external timer count into that channel's capture register. The timer itself lives outside; only its count arrives here as an input. Each channel can be set to react to rising edges, falling edges, both, or neither. Each channel can also be set to raise a pending flag when it captures.

A single eight-bit pending register gathers two kinds of events. Four match events come in from outside. The other four are capture events from the channels. Software reads this register to see which sources are pending. It clears sources by writing ones to their bits. One interrupt line reports whether any flag is pending.

Register access is a plain single-cycle port: a write strobe with address and data, and a read data bus that follows the address combinationally. There is no streaming traffic, so no valid/ready handshake exists and the bus never applies back-pressure.

Top module: `capture_irq_unit`

## Requirements
- R1: After reset, the pending register, the control register and all four capture registers read zero, and `irq_o` is low.
- R2: Each capture input passes through two synchroniser flops. If channel n samples its input low at clock edge k-1 and high at edge k, that is a rising edge. When the rising enable bit of channel n is set, capture register n loads the `tmr_count_i` value present at edge k+2.
- R3: A falling edge is sampled high at edge k-1 and low at edge k. When the falling enable bit of channel n is set, capture register n loads the count present at edge k+2.
- R4: With both enable bits set, a channel captures on every transition. With neither set, the capture register keeps its value.
- R5: A capture on channel n sets pending bit 4+n only when that channel's interrupt enable bit is set. The capture register loads either way.
- R6: A high `match_evt_i[n]` at a clock edge sets pending bit n.
- R7: A write to address 0 clears each pending bit whose data bit is one. Pending bits written with zero are left unchanged.
- R8: When a set event and a clear of the same pending bit fall on the same edge, the bit ends up set.
- R9: `irq_o` is high exactly when at least one pending bit is set.
- R10: Capture registers sit at addresses 2 to 5, for channels 0 to 3, and are read-only. Writes to those addresses change nothing.
- R11: The control register sits at address 1. Rising enables are bits 3:0, falling enables are bits 7:4 and interrupt enables are bits 11:8, with bit n of each field belonging to channel n. The pending register sits at address 0. Any other address reads zero. A control write takes effect for edges detected on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_count_i | input | 32 | Current timer count |
| cap_in_i | input | 4 | Asynchronous capture inputs, one per channel |
| match_evt_i | input | 4 | Match event pulses from the timer |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Any-pending interrupt |

## Verification
A wrong synchroniser stage count or a wrong edge polarity shows up as a capture value shifted by a multiple of the count step. It is visible at the capture address on the first read after the third clock edge that follows the input change. A pending flag that fails to set, clear or hold shows on `irq_o` and at address 0 in the very next cycle. A bad set-versus-clear priority is only exposed when a match event and its clear land on the same edge, so that collision is driven on purpose. A reference model compares every register and the interrupt line on every clock during a long pseudo-random stretch.

// File: rtl/cap_pkg.sv
package cap_pkg;
  parameter int unsigned CAP_CH  = 4;
  parameter int unsigned PEND_W  = 2 * CAP_CH;
  parameter int unsigned CTRL_W  = 3 * CAP_CH;
  parameter int unsigned ADDR_W  = 4;

  parameter logic [ADDR_W-1:0] ADR_PEND = 4'd0;
  parameter logic [ADDR_W-1:0] ADR_CTRL = 4'd1;
  parameter int unsigned       CAP_BASE = 2;

  typedef struct packed {
    logic [CAP_CH-1:0] irq_en;
    logic [CAP_CH-1:0] fall_en;
    logic [CAP_CH-1:0] rise_en;
  } cap_ctrl_t;
endpackage

// File: rtl/cap_edge_det.sv
module cap_edge_det #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cap_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  for (genvar i = 0; i < W; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1_q[i] <= 1'b0;
        s2_q[i] <= 1'b0;
        s3_q[i] <= 1'b0;
      end else begin
        s1_q[i] <= cap_i[i];
        s2_q[i] <= s1_q[i];
        s3_q[i] <= s2_q[i];
      end
    end

    assign rise_o[i] = s2_q[i] & ~s3_q[i];
    assign fall_o[i] = ~s2_q[i] & s3_q[i];

    AST_RISE_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[i] |-> $past(cap_i[i], 2)); // R2
    AST_FALL_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o[i] |-> !$past(cap_i[i], 2)); // R3
  end
endmodule

// File: rtl/cap_channel.sv
module cap_channel #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] cap_o
);
  logic [CNT_W-1:0] cap_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cap_q <= '0;
    else if (load_i) cap_q <= count_i;
  end

  assign cap_o = cap_q;

  AST_LOAD_TAKES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cap_q == $past(count_i))); // R2
  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(cap_q)); // R10
endmodule

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o,
  output logic         irq_o
);
  logic [W-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_i) | set_i;
  end

  assign flags_o = flags_q;
  assign irq_o   = |flags_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i))); // R8
  AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((~flags_q & $past(flags_q)) & ~$past(clr_i)) == '0); // R7
  AST_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & ~$past(flags_q)) & ~$past(set_i)) == '0); // R6
endmodule

// File: rtl/capture_irq_unit.sv
module capture_irq_unit
  import cap_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CNT_W-1:0]    tmr_count_i,
  input  logic [CAP_CH-1:0]   cap_in_i,
  input  logic [CAP_CH-1:0]   match_evt_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [CNT_W-1:0]    wdata_i,
  output logic [CNT_W-1:0]    rdata_o,
  output logic                irq_o
);
  cap_ctrl_t          ctrl_q;
  logic [CAP_CH-1:0]  rise, fall, load, cap_set;
  logic [PEND_W-1:0]  pend, pend_set, pend_clr;
  logic [CNT_W-1:0]   cap_val [CAP_CH];
  logic               unused_wbits;

  assign unused_wbits = ^wdata_i[CNT_W-1:CTRL_W];

  always_ff @(posedge clk) begin
    if (!rst_n)                            ctrl_q <= '0;
    else if (wr_en_i && addr_i == ADR_CTRL) ctrl_q <= cap_ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  cap_edge_det #(.W(CAP_CH)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_i  (cap_in_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign load    = (rise & ctrl_q.rise_en) | (fall & ctrl_q.fall_en);
  assign cap_set = load & ctrl_q.irq_en;

  for (genvar i = 0; i < CAP_CH; i++) begin : g_cap
    cap_channel #(.CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load[i]),
      .count_i (tmr_count_i),
      .cap_o   (cap_val[i])
    );
  end

  assign pend_set = {cap_set, match_evt_i};
  assign pend_clr = (wr_en_i && addr_i == ADR_PEND) ? wdata_i[PEND_W-1:0] : '0;

  irq_flags #(.W(PEND_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (pend_set),
    .clr_i   (pend_clr),
    .flags_o (pend),
    .irq_o   (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADR_PEND) rdata_o = CNT_W'(pend);
    if (addr_i == ADR_CTRL) rdata_o = CNT_W'(ctrl_q);
    for (int i = 0; i < CAP_CH; i++) begin
      if (addr_i == ADDR_W'(CAP_BASE + i)) rdata_o = cap_val[i];
    end
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && addr_i == ADR_CTRL) |=> $stable(ctrl_q)); // R11
  AST_CAPFLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend[PEND_W-1:CAP_CH] & ~$past(pend[PEND_W-1:CAP_CH])) & ~$past(ctrl_q.irq_en)) == '0); // R5
endmodule

// File: tb/test_capture_irq_unit.sv
`timescale 1ns/1ps
module test_capture_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tmr_count = '0;
  logic [3:0]  cap_in = '0;
  logic [3:0]  match_evt = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  capture_irq_unit i_capture_irq_unit (
    .clk(clk), .rst_n(rst_n), .tmr_count_i(tmr_count), .cap_in_i(cap_in),
    .match_evt_i(match_evt), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference model
  bit          hist [4][3];
  logic [31:0] m_cap [4];
  logic [7:0]  m_pend;
  logic [11:0] m_ctrl;

  always @(posedge clk) begin
    logic [7:0] setv;
    logic [7:0] clrv;
    if (!rst_n) begin
      m_pend = '0; m_ctrl = '0;
      for (int c = 0; c < 4; c++) begin
        m_cap[c] = '0;
        for (int j = 0; j < 3; j++) hist[c][j] = 1'b0;
      end
    end else begin
      setv = {4'b0, match_evt};
      for (int c = 0; c < 4; c++) begin
        bit r, f;
        r = hist[c][1] && !hist[c][2];
        f = !hist[c][1] && hist[c][2];
        if ((r && m_ctrl[c]) || (f && m_ctrl[4+c])) begin
          m_cap[c] = tmr_count;
          if (m_ctrl[8+c]) setv[4+c] = 1'b1;
        end
      end
      clrv = (wr_en && addr == 4'd0) ? wdata[7:0] : 8'h00;
      m_pend = (m_pend & ~clrv) | setv;
      if (wr_en && addr == 4'd1) m_ctrl = wdata[11:0];
      for (int c = 0; c < 4; c++) begin
        hist[c][2] = hist[c][1];
        hist[c][1] = hist[c][0];
        hist[c][0] = cap_in[c];
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [3:0] a);
    if (a == 4'd0) return {24'h0, m_pend};
    if (a == 4'd1) return {20'h0, m_ctrl};
    if (a >= 4'd2 && a <= 4'd5) return m_cap[a-2];
    return 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("R9 irq", {31'h0, irq}, {31'h0, (m_pend != 8'h00)});
      case (addr)
        4'd0: check("R7 pending", rdata, m_read(addr));
        4'd1: check("R11 control", rdata, m_read(addr));
        4'd2, 4'd3, 4'd4, 4'd5: check("R2 capture", rdata, m_read(addr));
        default: check("R11 unmapped", rdata, m_read(addr));
      endcase
    end
  end

  // timer count advances by 3 at each negedge
  always @(negedge clk) tmr_count <= tmr_count + 32'd3;

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd_check(input string tag, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk); addr = a; #1;
    check(tag, rdata, exp);
  endtask

  logic [31:0] v;
  logic [15:0] lfsr = 16'hACE1;

  initial begin
    cyc(3);
    #1;
    for (int a = 0; a < 6; a++) begin
      addr = 4'(a); #0.1;
      check("R1 reset reg", rdata, 32'h0);
    end
    check("R1 reset irq", {31'h0, irq}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    cyc(2);

    // R11: rising ch0 with irq
    wr(4'd1, 32'h0000_0101);
    rd_check("R11 ctrl readback", 4'd1, 32'h101);

    // R2: rising edge on ch0
    @(negedge clk); cap_in[0] = 1'b1; v = tmr_count + 32'd3;
    cyc(5);
    rd_check("R2 rise capture", 4'd2, v + 32'd6);
    rd_check("R5 flag with enable", 4'd0, 32'h10);
    check("R9 irq high", {31'h0, irq}, 32'h1);

    // R4: falling edge on ch0 without fall enable keeps value
    @(negedge clk); cap_in[0] = 1'b0;
    cyc(5);
    rd_check("R4 no fall enable", 4'd2, v + 32'd6);

    // R3 and R5: falling on ch1, no irq enable
    wr(4'd0, 32'hFF);
    wr(4'd1, 32'h0000_0020);
    @(negedge clk); cap_in[1] = 1'b1;
    cyc(5);
    rd_check("R3 rise ignored", 4'd3, 32'h0);
    @(negedge clk); cap_in[1] = 1'b0; v = tmr_count + 32'd3;
    cyc(5);
    rd_check("R3 fall capture", 4'd3, v + 32'd6);
    rd_check("R5 no flag without enable", 4'd0, 32'h0);

    // R4: both edges on ch2
    wr(4'd1, 32'h0000_0444);
    @(negedge clk); cap_in[2] = 1'b1; v = tmr_count + 32'd3;
    cyc(5);
    rd_check("R4 both rise", 4'd4, v + 32'd6);
    @(negedge clk); cap_in[2] = 1'b0; v = tmr_count + 32'd3;
    cyc(5);
    rd_check("R4 both fall", 4'd4, v + 32'd6);
    rd_check("R5 flag ch2", 4'd0, 32'h40);

    // R6: match events
    @(negedge clk); match_evt = 4'b1011;
    @(negedge clk); match_evt = 4'b0000;
    rd_check("R6 match flags", 4'd0, 32'h4B);

    // R7: partial clear
    wr(4'd0, 32'h0000_0001);
    rd_check("R7 partial clear", 4'd0, 32'h4A);

    // R8: clear and set same edge
    @(negedge clk); wr_en = 1'b1; addr = 4'd0; wdata = 32'h02; match_evt = 4'b0010;
    @(negedge clk); wr_en = 1'b0; wdata = '0; match_evt = '0;
    rd_check("R8 set wins", 4'd0, 32'h4A);

    // R10: write to capture register ignored
    v = m_cap[0];
    wr(4'd2, 32'hDEAD_BEEF);
    rd_check("R10 capture read-only", 4'd2, v);

    // R9: clear all
    wr(4'd0, 32'hFF);
    rd_check("R9 all clear", 4'd0, 32'h0);
    check("R9 irq low", {31'h0, irq}, 32'h0);
    rd_check("R11 unmapped", 4'd9, 32'h0);

    // pseudo-random stretch checked every cycle against the model
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cap_in = lfsr[3:0];
      match_evt = (lfsr[7:4] == 4'hF) ? lfsr[11:8] : 4'h0;
      wr_en = (lfsr[15:13] == 3'b101);
      addr = lfsr[12:9];
      wdata = {16'h0, lfsr};
    end
    @(negedge clk); wr_en = 1'b0; cap_in = '0; match_evt = '0;
    cyc(4);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule